// File: doc/BRIEF.md
# 64B/66B Block Boundary Aligner

This block sits behind a serial receiver that delivers one recovered line bit per clock. It cuts that stream into 66-bit blocks and looks for the one bit offset where every block begins with a two-bit header whose bits differ. While it searches, it tests one candidate offset at a time. When the header at the candidate offset is invalid, it moves the candidate one bit later. A single valid header does not prove anything, because opposite bit pairs also turn up inside payload. The candidate is accepted only after a long unbroken run of valid headers.

Once locked, the aligner keeps checking each header. It counts invalid headers in fixed windows of blocks. When too many fall inside one window, it drops lock and raises a one-cycle resynchronisation request. Upstream logic uses that request to reset the multiblock clock alignment with a fresh SYSREF. The block then searches again. It always outputs each 66-bit block with a valid strobe and the two header bits, whether locked or not, so downstream logic can qualify the data with the lock flag.

Top module: `blk_aligner66`

## Requirements
- R1: A synchronous active-high reset clears the lock flag, the block valid strobe and the resync request. After reset the first candidate block is the first 66 bits received after reset is released.
- R2: Each block is presented with a one-cycle `blockValid` pulse. The pulse comes in the cycle after the block's last bit is captured. `blockData[0]` is the earliest received bit of the block, and `syncHdr` equals `blockData[1:0]`. A header is valid when its two bits differ (01 or 10) and invalid when they are 00 or 11.
- R3: While searching, an invalid header moves the candidate boundary one bit later. The next `blockValid` then comes 67 cycles after the previous one instead of 66.
- R4: Lock is declared after LOCK_COUNT (default 64) consecutive valid headers at one candidate offset. `locked` rises in the cycle after the strobe of the last of those blocks.
- R5: While locked, the boundary never moves. Blocks keep arriving every 66 cycles with unchanged content, including blocks whose header is invalid. Fewer than BAD_LIMIT invalid headers inside a window leave the lock in place.
- R6: While locked, invalid headers are counted in consecutive windows of WIN_BLOCKS (default 64) blocks. The first window starts with the first block after lock. The count restarts at each window, so invalid headers split across two windows do not add up.
- R7: The BAD_LIMIT-th (default 16) invalid header inside one window clears `locked` and pulses `resyncReq` for exactly one cycle, in the same cycle. The search then restarts from the current offset with its run count at zero.
- R8: For any starting bit offset of the incoming block stream, the aligner reaches lock at the true boundary, and the blocks it delivers then match the transmitted blocks bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lineBit | input | 1 | Recovered serial line bit |
| blockData | output | 66 | Assembled block, bit 0 received first |
| syncHdr | output | 2 | Header bits of the presented block |
| blockValid | output | 1 | One-cycle strobe marking a new block |
| locked | output | 1 | Boundary found and being tracked |
| resyncReq | output | 1 | One-cycle request to realign the multiblock clock |

## Verification
A wrong bit counter or a wrong slip shows up at the ports within one block period. Strobes come 65 or 68 cycles apart, or the delivered words no longer match the transmitted blocks once lock is up. A wrong run counter or window counter moves the exact block at which `locked` rises or falls. The bench predicts that block index arithmetically from the stream it drives, so an off-by-one in either counter is seen at the first lock or drop event. A resync pulse that is missing, doubled or mistimed against the fall of `locked` is caught in the sample right after the drop.

// File: rtl/blk_align_pkg.sv
package blk_align_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic slip;
  } align_ctl_t;

  // datapath -> control header event
  typedef struct packed {
    logic done;
    logic hdrOk;
  } hdr_evt_t;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } align_state_t;

endpackage

// File: rtl/blk_shift_path.sv
module blk_shift_path
  import blk_align_pkg::*;
#(
  parameter int BLOCK_BITS = 66
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lineBit,
  input  align_ctl_t            ctl,
  output logic [BLOCK_BITS-1:0] blockData,
  output logic                  blockValid,
  output hdr_evt_t              evt
);

  localparam int CNT_W = $clog2(BLOCK_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLOCK_BITS - 1);

  logic [BLOCK_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]      bitCnt;
  logic [BLOCK_BITS-1:0] nextWord;

  // newest bit enters at the top; after a full block bit 0 is the oldest
  assign nextWord = {lineBit, shiftReg[BLOCK_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg   <= '0;
      bitCnt     <= '0;
      blockData  <= '0;
      blockValid <= 1'b0;
    end else begin
      shiftReg   <= nextWord;
      blockValid <= 1'b0;
      if (bitCnt == CNT_LAST) begin
        blockData  <= nextWord;
        blockValid <= 1'b1;
        bitCnt     <= '0;
      end else if (!ctl.slip) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
      // on slip the count holds one cycle: the boundary moves one bit later
    end
  end

  assign evt.done  = blockValid;
  assign evt.hdrOk = blockData[0] ^ blockData[1];

  // R2: one strobe per block, never two in a row
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    blockValid |=> !blockValid);

  // R3: a slip arrives only with a fresh block and only at its first bit slot
  assert_slip_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    ctl.slip |-> (blockValid && bitCnt == '0));

endmodule

// File: rtl/blk_lock_ctl.sv
module blk_lock_ctl
  import blk_align_pkg::*;
#(
  parameter int LOCK_COUNT = 64,
  parameter int WIN_BLOCKS = 64,
  parameter int BAD_LIMIT  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  hdr_evt_t   evt,
  output align_ctl_t ctl,
  output logic       locked,
  output logic       resyncReq
);

  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam int WIN_W  = $clog2(WIN_BLOCKS + 1);
  localparam int BAD_W  = $clog2(BAD_LIMIT + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_BLOCKS - 1);
  localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(BAD_LIMIT - 1);

  align_state_t      state;
  logic [GOOD_W-1:0] goodCnt;
  logic [WIN_W-1:0]  winCnt;
  logic [BAD_W-1:0]  badCnt;

  always_comb begin
    ctl      = '0;
    ctl.slip = (state == ST_SEARCH) && evt.done && !evt.hdrOk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SEARCH;
      goodCnt   <= '0;
      winCnt    <= '0;
      badCnt    <= '0;
      resyncReq <= 1'b0;
    end else begin
      resyncReq <= 1'b0;
      if (evt.done) begin
        case (state)
          ST_SEARCH: begin
            if (!evt.hdrOk) begin
              goodCnt <= '0;
            end else if (goodCnt == GOOD_LAST) begin
              state   <= ST_LOCKED;
              goodCnt <= '0;
              winCnt  <= '0;
              badCnt  <= '0;
            end else begin
              goodCnt <= goodCnt + GOOD_W'(1);
            end
          end
          ST_LOCKED: begin
            if (!evt.hdrOk && badCnt == BAD_LAST) begin
              state     <= ST_SEARCH;
              resyncReq <= 1'b1;
              goodCnt   <= '0;
            end else if (winCnt == WIN_LAST) begin
              winCnt <= '0;
              badCnt <= '0;
            end else begin
              winCnt <= winCnt + WIN_W'(1);
              if (!evt.hdrOk) badCnt <= badCnt + BAD_W'(1);
            end
          end
          default: state <= ST_SEARCH;
        endcase
      end
    end
  end

  assign locked = (state == ST_LOCKED);

  // R4: lock only ever follows a block with a valid header
  assert_lock_on_valid_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(evt.done && evt.hdrOk));

  // R5: no boundary movement while locked
  assert_no_slip_locked_R5: assert property (@(posedge clk) disable iff (rst)
    locked |-> !ctl.slip);

  // R7: losing lock and the resync request go together
  assert_drop_with_resync_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> resyncReq);

  // R7: the request lasts one cycle and never coexists with lock
  assert_resync_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    resyncReq |-> (!locked ##1 !resyncReq));

endmodule

// File: rtl/blk_aligner66.sv
module blk_aligner66
  import blk_align_pkg::*;
#(
  parameter int BLOCK_BITS = 66,
  parameter int LOCK_COUNT = 64,
  parameter int WIN_BLOCKS = 64,
  parameter int BAD_LIMIT  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lineBit,
  output logic [BLOCK_BITS-1:0] blockData,
  output logic [1:0]            syncHdr,
  output logic                  blockValid,
  output logic                  locked,
  output logic                  resyncReq
);

  align_ctl_t ctl;
  hdr_evt_t   evt;

  blk_shift_path #(
    .BLOCK_BITS(BLOCK_BITS)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .lineBit   (lineBit),
    .ctl       (ctl),
    .blockData (blockData),
    .blockValid(blockValid),
    .evt       (evt)
  );

  blk_lock_ctl #(
    .LOCK_COUNT(LOCK_COUNT),
    .WIN_BLOCKS(WIN_BLOCKS),
    .BAD_LIMIT (BAD_LIMIT)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .ctl      (ctl),
    .locked   (locked),
    .resyncReq(resyncReq)
  );

  assign syncHdr = blockData[1:0];

endmodule

// File: tb/blk_aligner66_test.sv
module blk_aligner66_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lineBit = 1'b0;
  logic [65:0] blockData;
  logic [1:0]  syncHdr;
  logic        blockValid, locked, resyncReq;

  blk_aligner66 uut (
    .clk(clk), .rst(rst), .lineBit(lineBit), .blockData(blockData),
    .syncHdr(syncHdr), .blockValid(blockValid), .locked(locked),
    .resyncReq(resyncReq)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [31:0] rngState = 32'h1357_9bdf;
  logic [65:0] lastBlk;
  bit  checkData, armData, prevLocked;
  int  rxCount, lockRx, lockRises, dropRx, resyncCnt, resyncWhileLocked;
  int  dropNoResync, dataErr, gapErr, lastVCyc, nValid;
  int  vCyc [4];

  function automatic logic [31:0] nextRand();
    rngState ^= rngState << 13;
    rngState ^= rngState >> 17;
    rngState ^= rngState << 5;
    return rngState;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearStats();
    rxCount = 0; lockRx = -1; lockRises = 0; dropRx = -1; resyncCnt = 0;
    resyncWhileLocked = 0; dropNoResync = 0; dataErr = 0; gapErr = 0;
    lastVCyc = -1; nValid = 0; prevLocked = 0; checkData = 0; armData = 0;
  endtask

  // drive one bit, then sample the outputs at the following falling edge
  task automatic step(input logic b);
    lineBit = b;
    @(negedge clk);
    if (resyncReq) begin
      resyncCnt++;
      if (locked) resyncWhileLocked++;
    end
    if (prevLocked && !locked) begin
      dropRx = rxCount;
      if (!resyncReq) dropNoResync++;
    end
    if (locked && !prevLocked) begin
      lockRx = rxCount;
      lockRises++;
    end
    prevLocked = locked;
    if (blockValid) begin
      if (nValid < 4) vCyc[nValid] = cyc;
      nValid++;
      if (checkData && blockData != lastBlk) dataErr++;
      if (checkData && syncHdr != lastBlk[1:0]) dataErr++;
      if (locked && lastVCyc >= 0 && (cyc - lastVCyc) != 66) gapErr++;
      lastVCyc = cyc;
      rxCount++;
    end
    if (armData && locked) checkData = 1;
  endtask

  task automatic sendBlock(input int idx, input bit corrupt);
    logic [65:0] blk;
    blk[33:2]  = nextRand();
    blk[65:34] = nextRand();
    if (corrupt) blk[1:0] = idx[0] ? 2'b11 : 2'b00;
    else         blk[1:0] = {idx[0], ~idx[0]};
    for (int i = 0; i < 66; i++) begin
      if (i == 65) lastBlk = blk;
      step(blk[i]);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    lineBit = 1'b0;
    repeat (3) @(negedge clk);
    check(!locked && !blockValid && !resyncReq, "R1", "outputs in reset",
          {locked, blockValid, resyncReq}, 0);
    clearStats();
    rst = 1'b0;
  endtask

  function automatic bit isBad(input int idx);
    return (idx >= 70 && idx <= 84) || (idx >= 184 && idx <= 199) ||
           (idx >= 256 && idx <= 271);
  endfunction

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  initial begin
    // ---- Scenario A: aligned stream, lock/drop/relock timing ----
    doReset();
    checkData = 1;
    for (int k = 0; k <= 340; k++) begin
      sendBlock(k, isBad(k));
      if (k == 0) check(nValid == 1 && vCyc[0] == 66 + vCyc[0] - 66, "R1",
                        "first block is first 66 bits", nValid, 1);
      if (k == 100) check(locked, "R5", "15 bad in a window kept lock", locked, 1);
      if (k == 230) check(locked, "R6", "bad split over two windows kept lock", locked, 1);
    end
    check(dataErr == 0, "R2", "block data and header match sent blocks", dataErr, 0);
    check(gapErr == 0, "R5", "66-cycle strobe spacing while locked", gapErr, 0);
    check(dropRx == 272, "R7", "lock dropped after 16th bad header", dropRx, 272);
    check(resyncCnt == 1, "R7", "exactly one resync cycle", resyncCnt, 1);
    check(resyncWhileLocked == 0 && dropNoResync == 0, "R7",
          "resync coincides with drop", resyncWhileLocked + dropNoResync, 0);
    check(lockRises == 2, "R6", "two lock events", lockRises, 2);
    check(lockRx == 336, "R4", "relock after 64 fresh valid headers", lockRx, 336);
    check(locked, "R7", "search restarted at same offset", locked, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!locked, "R1", "reset clears lock while locked", locked, 0);

    // first lock timing of an aligned stream
    doReset();
    checkData = 1;
    for (int k = 0; k < 66; k++) sendBlock(k, 1'b0);
    check(lockRx == 64, "R4", "first lock after 64 valid headers", lockRx, 64);
    check(nValid >= 2 && vCyc[1] - vCyc[0] == 66, "R2", "strobe period 66",
          vCyc[1] - vCyc[0], 66);

    // ---- Scenario B: one extra leading bit forces a single slip ----
    doReset();
    step(1'b1);               // with block 0 bit 0 = 1 makes header 11
    for (int k = 0; k < 80; k++) begin
      if (k == 1) checkData = 1;
      sendBlock(k, 1'b0);
    end
    check(vCyc[1] - vCyc[0] == 67, "R3", "slip stretches one block by a bit",
          vCyc[1] - vCyc[0], 67);
    check(vCyc[2] - vCyc[1] == 66, "R3", "no slip after valid header",
          vCyc[2] - vCyc[1], 66);
    check(lockRx == 65, "R4", "lock after slip plus 64 valid", lockRx, 65);
    check(dataErr == 0, "R3", "data aligned after slip", dataErr, 0);

    // ---- Scenario C: sweep of starting offsets ----
    foreach (vCyc[i]) vCyc[i] = 0;
    for (int s = 0; s < 4; s++) begin
      int d;
      int k;
      int after;
      d = (s == 0) ? 7 : (s == 1) ? 33 : (s == 2) ? 50 : 65;
      doReset();
      armData = 1;
      for (int j = 0; j < d; j++) step(nextRand() & 32'h1);
      k = 0;
      after = 0;
      while (k < 500 && after < 20) begin
        sendBlock(k, 1'b0);
        if (checkData) after++;
        k++;
      end
      check(lockRises == 1 && locked, "R8", "lock found at offset", d, d);
      check(dataErr == 0 && after == 20, "R8", "blocks match after lock",
            dataErr, 0);
      check(gapErr == 0, "R5", "steady spacing after lock", gapErr, 0);
    end

    finishRun();
  end

endmodule